// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a programmable countdown timer that feeds one local interrupt source. Software sets a 32-bit start value, picks a clock divisor through a 4-bit configuration field, and programs the timer's interrupt entry. The entry holds a vector, a mask bit and a bit that selects one-shot or periodic operation. The counter steps down once per divided period of an external bus tick. When it reaches its end, the timer records an expiration in a small pending counter. If the unit is enabled and the timer entry is unmasked, it then requests service from the interrupt controller and presents the entry's vector.

The register port also holds the unit's software enable and six local interrupt entries. Entry 0 is the timer's own entry. Entries 1 to 5 are storage for the neighbouring local sources. The controller answers the request with an accept strobe, and each accept removes one pending expiration. The pending counter saturates and does not wrap. Writing a new start value, or clearing the software enable, throws away all pending expirations.

Top module: `lvt_timer`

## Requirements
- R1: After reset the enable reads 0, the start and current counts read 0, the divide field reads 0, every interrupt entry reads 0x0001_0000 (only the mask bit, bit 16, set), and irq_req is low.
- R2: The divisor is 2^((c+1) mod 8). Here c is the 3-bit code {cfg[3], cfg[1], cfg[0]}, so code 7 divides by 1 and code 0 divides by 2. cfg[2] has no effect on the divisor.
- R3: A write to the start count (address 0x1) reloads the current count with the written value on the next cycle, restarts the divisor prescaler from zero and clears all pending expirations.
- R4: With a start count of 0 the timer is stopped. The current count (address 0x2) reads 0 and no expiration occurs, however many ticks arrive.
- R5: In one-shot mode (entry bit 17 = 0), with start value N and divisor D, the current count reads N - floor(k/D) after k ticks. It reads 0 from tick N*D onward, and exactly one expiration is recorded.
- R6: In periodic mode (entry bit 17 = 1) the current count reads N - (floor(k/D) mod N) after k ticks, and one expiration is recorded every N*D ticks.
- R7: An entry write (addresses 0x8 to 0xD, entry i at 0x8+i) keeps only bits 7:0 (vector), 12 (delivery status), 16 (mask) and 17 (periodic). All other bits read back 0.
- R8: An entry written while the enable (control address 0x0, bit 0) is 0 has its mask bit forced to 1.
- R9: A control write with bit 0 = 0 sets the mask bit of all six entries and clears the pending expirations.
- R10: irq_req is high only while expirations are pending, the unit is enabled and entry 0 is unmasked. irq_vector then equals entry 0 bits 7:0. Each cycle with irq_req and irq_ack both high removes exactly one pending expiration.
- R11: The pending counter saturates at 2^PEND_W - 1 (15 by default) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| tick | input | 1 | Bus clock tick, one count event per cycle high |
| irq_req | output | 1 | Interrupt request toward the controller |
| irq_vector | output | 8 | Vector presented with the request |
| irq_ack | input | 1 | Controller accepts the request this cycle |

## Verification
The hardest state to reach from the ports is a full pending counter. Reaching it takes many expirations while nothing can be observed, because a request only appears when the entry is unmasked. The bench gets there with start value 1, divide-by-1 and a masked entry, and ticks well beyond fifteen expirations. It then freezes the tick, unmasks the entry and counts accepts until the request drops. The divisor mapping is covered by sweeping all eight codes, each with a one-shot countdown that the bench checks tick by tick against arithmetic expectations.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;

    localparam int unsigned WORD_W = 32;

    // register addresses
    localparam int unsigned ADDR_CTRL     = 0;
    localparam int unsigned ADDR_INIT     = 1;
    localparam int unsigned ADDR_CUR      = 2;
    localparam int unsigned ADDR_DIV      = 3;
    localparam int unsigned ADDR_LVT_BASE = 8;

    // interrupt entry fields
    localparam int unsigned ENT_MASK_BIT     = 16;
    localparam int unsigned ENT_PERIODIC_BIT = 17;
    localparam logic [WORD_W-1:0] ENT_WRITABLE = 32'h0003_10FF;
    localparam logic [WORD_W-1:0] ENT_RESET    = 32'h0001_0000;

    // code taken from the divide field: bits 3, 1, 0
    function automatic logic [2:0] div_code(input logic [3:0] cfg);
        return {cfg[3], cfg[1], cfg[0]};
    endfunction

endpackage

// File: rtl/lvt_timer_prescaler.sv
module lvt_timer_prescaler #(
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              div_tick
);
    localparam int unsigned PRESC_W = (1 << CODE_W) - 1;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
    } presc_state_t;

    presc_state_t st_d, st_q;
    logic [CODE_W-1:0]  shift;
    logic [PRESC_W:0]   divisor;
    logic [PRESC_W-1:0] limit;

    always_comb begin
        shift    = code + CODE_W'(1);
        divisor  = (PRESC_W+1)'(1) << shift;
        limit    = PRESC_W'(divisor - (PRESC_W+1)'(1));
        st_d     = st_q;
        div_tick = 1'b0;
        if (restart) begin
            st_d.presc = '0;
        end else if (tick) begin
            if (st_q.presc >= limit) begin
                st_d.presc = '0;
                div_tick   = 1'b1;
            end else begin
                st_d.presc = st_q.presc + PRESC_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/lvt_timer_countdown.sv
module lvt_timer_countdown #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             div_tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.count   = load_val;
            st_d.running = |load_val;
        end else if (div_tick && st_q.running) begin
            if (st_q.count == CNT_W'(1)) begin
                expire = 1'b1;
                if (periodic && (|reload_val)) begin
                    st_d.count = reload_val;
                end else begin
                    st_d.count   = '0;
                    st_d.running = 1'b0;
                end
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

endmodule

// File: rtl/lvt_timer_pending.sv
module lvt_timer_pending #(
    parameter int unsigned PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              expire,
    input  logic              accept,
    output logic [PEND_W-1:0] pend,
    output logic              any
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    typedef struct packed {
        logic [PEND_W-1:0] cnt;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else begin
            unique case ({expire, accept})
                2'b10: if (st_q.cnt != PEND_MAX) st_d.cnt = st_q.cnt + PEND_W'(1);
                2'b01: if (st_q.cnt != '0)       st_d.cnt = st_q.cnt - PEND_W'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.cnt;
    assign any  = |st_q.cnt;

endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
    import lvt_timer_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned NUM_LVT = 6,
    parameter int unsigned PEND_W  = 4,
    parameter int unsigned CODE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              tick,
    output logic              irq_req,
    output logic [7:0]        irq_vector,
    input  logic              irq_ack
);
    typedef logic [NUM_LVT-1:0][WORD_W-1:0] lvt_array_t;

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] init;
        logic [3:0]        div_cfg;
        lvt_array_t        lvt;
    } regs_t;

    regs_t rq_d, rq_q;

    logic [NUM_LVT-1:0] lvt_hit;
    logic               hit_ctrl, hit_init, hit_div;
    logic               disable_wr;
    logic               pend_clear;
    logic               div_tick;
    logic               expire;
    logic               pend_any;
    logic               accept;
    logic [WORD_W-1:0]  cur_count;
    logic [PEND_W-1:0]  pend_cnt;
    logic [WORD_W-1:0]  lvt_wr_val;
    lvt_array_t         lvt_q;
    logic [WORD_W-1:0]  timer_ent;

    assign hit_ctrl   = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    assign hit_init   = wr_en && (wr_addr == ADDR_W'(ADDR_INIT));
    assign hit_div    = wr_en && (wr_addr == ADDR_W'(ADDR_DIV));
    assign disable_wr = hit_ctrl && !wr_data[0];
    assign pend_clear = hit_init || disable_wr;

    // per-entry write decode
    for (genvar g = 0; g < NUM_LVT; g++) begin : g_lvt_hit
        assign lvt_hit[g] = wr_en && (wr_addr == ADDR_W'(ADDR_LVT_BASE + g));
    end

    always_comb begin
        lvt_wr_val = wr_data & ENT_WRITABLE;
        if (!rq_q.en) lvt_wr_val[ENT_MASK_BIT] = 1'b1;
    end

    always_comb begin
        rq_d = rq_q;
        if (hit_ctrl) rq_d.en = wr_data[0];
        if (hit_init) rq_d.init = wr_data;
        if (hit_div)  rq_d.div_cfg = wr_data[3:0];
        for (int i = 0; i < NUM_LVT; i++) begin
            if (lvt_hit[i]) rq_d.lvt[i] = lvt_wr_val;
            if (disable_wr) rq_d.lvt[i][ENT_MASK_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_q.en      <= 1'b0;
            rq_q.init    <= '0;
            rq_q.div_cfg <= '0;
            for (int i = 0; i < NUM_LVT; i++) rq_q.lvt[i] <= ENT_RESET;
        end else begin
            rq_q <= rq_d;
        end
    end

    assign lvt_q     = rq_q.lvt;
    assign timer_ent = rq_q.lvt[0];

    lvt_timer_prescaler #(.CODE_W(CODE_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (hit_init),
        .tick     (tick),
        .code     (CODE_W'(div_code(rq_q.div_cfg))),
        .div_tick (div_tick)
    );

    lvt_timer_countdown #(.CNT_W(WORD_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (hit_init),
        .load_val   (wr_data),
        .reload_val (rq_q.init),
        .periodic   (timer_ent[ENT_PERIODIC_BIT]),
        .div_tick   (div_tick),
        .count      (cur_count),
        .expire     (expire)
    );

    assign irq_req    = pend_any && rq_q.en && !timer_ent[ENT_MASK_BIT];
    assign irq_vector = timer_ent[7:0];
    assign accept     = irq_req && irq_ack;

    lvt_timer_pending #(.PEND_W(PEND_W)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (pend_clear),
        .expire (expire),
        .accept (accept),
        .pend   (pend_cnt),
        .any    (pend_any)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_CTRL))      rd_data = {31'b0, rq_q.en};
        else if (rd_addr == ADDR_W'(ADDR_INIT)) rd_data = rq_q.init;
        else if (rd_addr == ADDR_W'(ADDR_CUR))  rd_data = cur_count;
        else if (rd_addr == ADDR_W'(ADDR_DIV))  rd_data = {28'b0, rq_q.div_cfg};
        else begin
            for (int i = 0; i < NUM_LVT; i++) begin
                if (rd_addr == ADDR_W'(ADDR_LVT_BASE + i)) rd_data = rq_q.lvt[i];
            end
        end
    end

endmodule

// File: rtl/lvt_timer_checker.sv
module lvt_timer_checker
    import lvt_timer_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned NUM_LVT = 6,
    parameter int unsigned PEND_W  = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_en,
    input logic [ADDR_W-1:0]              wr_addr,
    input logic [31:0]                    wr_data,
    input logic                           irq_req,
    input logic                           irq_ack,
    input logic                           en,
    input logic [NUM_LVT-1:0][WORD_W-1:0] lvt_all,
    input logic [PEND_W-1:0]              pend,
    input logic [WORD_W-1:0]              count,
    input logic                           expire
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    logic [NUM_LVT-1:0] masks;
    logic               init_wr, ctrl_off_wr;

    for (genvar g = 0; g < NUM_LVT; g++) begin : g_masks
        assign masks[g] = lvt_all[g][ENT_MASK_BIT];
    end

    assign init_wr     = wr_en && (wr_addr == ADDR_W'(ADDR_INIT));
    assign ctrl_off_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL)) && !wr_data[0];

    assert_req_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (en && !lvt_all[0][ENT_MASK_BIT] && (pend != '0)));

    assert_accept_dec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !expire && !wr_en) |=> (pend == $past(pend) - PEND_W'(1)));

    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == PEND_MAX && !irq_ack && !wr_en) |=> (pend == PEND_MAX));

    assert_init_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (count == $past(wr_data) && pend == '0));

    assert_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !init_wr) |=> (count == '0 && !expire));

    assert_disable_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_off_wr |=> (&masks && pend == '0 && !irq_req));

endmodule

bind lvt_timer lvt_timer_checker #(
    .ADDR_W  (ADDR_W),
    .NUM_LVT (NUM_LVT),
    .PEND_W  (PEND_W)
) u_lvt_timer_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq_req (irq_req),
    .irq_ack (irq_ack),
    .en      (rq_q.en),
    .lvt_all (lvt_q),
    .pend    (pend_cnt),
    .count   (cur_count),
    .expire  (expire)
);

// File: tb/lvt_timer_bench.sv
module lvt_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tick = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vector;
    logic        irq_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lvt_timer u_lvt_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .tick       (tick),
        .irq_req    (irq_req),
        .irq_vector (irq_vector),
        .irq_ack    (irq_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // all tasks are entered at a falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    // count accepts until the request drops
    task automatic drain(output int n);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            if (irq_req) begin n++; irq_ack = 1'b1; end
            else irq_ack = 1'b0;
            @(negedge clk);
        end
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); chk("R1 ctrl", v, 32'h0);
        rd(4'h1, v); chk("R1 init", v, 32'h0);
        rd(4'h2, v); chk("R1 cur", v, 32'h0);
        rd(4'h3, v); chk("R1 div", v, 32'h0);
        for (int e = 0; e < 6; e++) begin
            rd(4'(8 + e), v); chk("R1 entry", v, 32'h0001_0000);
        end
        chk("R1 req", {31'b0, irq_req}, 32'h0);

        // R8 entry write while disabled keeps mask
        wr(4'hA, 32'h0000_0042);
        rd(4'hA, v); chk("R8 forced mask", v, 32'h0001_0042);

        // R7 writable bits
        wr(4'h0, 32'h1);
        wr(4'h9, 32'hFFFF_FFFF);
        rd(4'h9, v); chk("R7 writable bits", v, 32'h0003_10FF);
        wr(4'h9, 32'h0000_0011);
        rd(4'h9, v); chk("R7 unmasked write", v, 32'h0000_0011);

        // R2/R5 sweep of all divide codes, one-shot, N=3
        wr(4'h8, 32'h0000_0030);
        for (int code = 0; code < 8; code++) begin
            int d;
            int nn;
            logic [3:0] cfg;
            d   = 1 << ((code + 1) % 8);
            nn  = 3;
            cfg = {code[2], code[0], code[1], code[0]};
            wr(4'h3, {28'b0, cfg});
            wr(4'h1, 32'(nn));
            chk("R3 pending cleared by start write", {31'b0, irq_req}, 32'h0);
            rd(4'h2, v); chk("R3 cur loaded", v, 32'(nn));
            for (int k = 1; k <= nn * d + 2; k++) begin
                int ecur;
                ticks(1);
                ecur = (k < nn * d) ? nn - k / d : 0;
                rd(4'h2, v); chk("R2 R5 cur count", v, 32'(ecur));
                chk("R5 expiry request", {31'b0, irq_req}, {31'b0, k >= nn * d});
            end
            chk("R10 vector", {24'b0, irq_vector}, 32'h30);
            drain(n); chk("R5 single expiry", 32'(n), 32'd1);
        end

        // R3 restart mid-run and prescaler reset (divide by 4: code 1)
        wr(4'h3, 32'h1);
        wr(4'h1, 32'd2);
        ticks(3);
        wr(4'h1, 32'd2);
        ticks(3);
        rd(4'h2, v); chk("R3 prescaler restarted", v, 32'd2);
        ticks(1);
        rd(4'h2, v); chk("R3 count after restart", v, 32'd1);

        // R4 zero start count stops
        wr(4'h1, 32'd0);
        ticks(20);
        rd(4'h2, v); chk("R4 cur zero", v, 32'h0);
        chk("R4 no request", {31'b0, irq_req}, 32'h0);

        // R6 periodic, N=4, divide by 2 (code 0), masked while running
        wr(4'h3, 32'h0);
        wr(4'h8, 32'h0003_0031);
        wr(4'h1, 32'd4);
        for (int k = 1; k <= 30; k++) begin
            ticks(1);
            rd(4'h2, v); chk("R6 periodic cur", v, 32'(4 - ((k / 2) % 4)));
        end
        chk("R10 masked no request", {31'b0, irq_req}, 32'h0);
        wr(4'h8, 32'h0002_0031);
        chk("R10 request after unmask", {31'b0, irq_req}, 32'h1);
        chk("R10 vector periodic", {24'b0, irq_vector}, 32'h31);
        drain(n); chk("R6 expirations", 32'(n), 32'd3);

        // R11 saturation: N=1, divide by 1 (code 7 -> cfg 4'b1011)
        wr(4'h3, 32'hB);
        wr(4'h8, 32'h0003_0032);
        wr(4'h1, 32'd1);
        ticks(25);
        chk("R11 masked", {31'b0, irq_req}, 32'h0);
        wr(4'h8, 32'h0002_0032);
        drain(n); chk("R11 saturated count", 32'(n), 32'd15);

        // R9 disable masks all and drops pending
        for (int e = 1; e < 6; e++) wr(4'(8 + e), 32'h0000_0020);
        ticks(3);
        chk("R9 request before disable", {31'b0, irq_req}, 32'h1);
        wr(4'h0, 32'h0);
        for (int e = 0; e < 6; e++) begin
            rd(4'(8 + e), v); chk("R9 mask set", {31'b0, v[16]}, 32'h1);
        end
        wr(4'h1, 32'd0);
        wr(4'h0, 32'h1);
        wr(4'h8, 32'h0000_0032);
        chk("R9 pending cleared", {31'b0, irq_req}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule